// File: doc/BRIEF.md
# Window Watchdog Timer

This block is a memory-mapped watchdog timer with a window. A software agent programs it through a plain 32-bit register port that has an address, a write strobe, write data and registered read data. Each timing period has two phases. The first is a closed window, where a refresh counts as a fault. The second is an open window, where software must refresh. If the open window runs out, or if a refresh arrives too early, the block pulses its reset output for one clock. After that it starts a new period.

Software cannot change the control and count registers directly. It must first arm a key register, and the key covers only the single write that follows. A refresh is made by writing the window-select bit from 0 to 1. A sticky interrupt flag rises each time the open window begins, and software clears it by writing a 1 to it. All counting is in clock cycles.

Top module: `win_watchdog`

## Requirements
- R1: After synchronous reset, every register reads 0, and `wdt_rst_o` and `irq_o` are low.
- R2: A write of 1 to bit 0 at offset 0x00 arms the key. The key reads back at bit 0 of offset 0x00. Any write to a different offset disarms it, whether or not that write takes effect.
- R3: A write to offset 0x04 (control), 0x08 (configuration), 0x0C (closed-window count) or 0x10 (open-window count) is ignored unless the key is armed at that time.
- R4: Control bit 0 is the enable. Writing it from 0 to 1 starts a period. Writing it as 0 stops all counting. While the block is disabled, `wdt_rst_o` stays low.
- R5: With closed-window count F greater than 0 and open-window count S, and no refresh, `wdt_rst_o` is high for exactly one cycle, F+S cycles after the enabling write edge. A new period then begins. An open-window count of 1 expires one cycle after the period starts, and a count of 0 behaves as 1.
- R6: A refresh is an accepted control write with bit 0 = 1 and bit 8 = 1 while the stored bit 8 is 0 and the block is enabled. A refresh in the open window restarts the period with no reset. A refresh in the closed window raises `wdt_rst_o` in the next cycle and restarts the period. Writing bit 8 as 1 when it is already 1 does nothing.
- R7: A closed-window count of 0 starts every period directly in the open window.
- R8: Control bit 16 (`irq_o`) is set each time the open window is entered. An accepted control write with bit 16 = 1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: `rd_data` is registered. It shows the register addressed in the previous cycle. Offset 0x04 returns enable at bit 0, select at bit 8 and interrupt at bit 16. Offsets 0x08, 0x0C and 0x10 return their stored values. Any other offset returns 0. The configuration register has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| wdt_rst_o | output | 1 | Watchdog reset pulse |
| irq_o | output | 1 | Open-window interrupt status |

## Verification
The bench targets the following corner cases:
- A refresh that lands on the last closed-window cycle must count as a violation. A design that lets the window advance first would miss the fault.
- A select write of 1 while select is already 1 must not be treated as a refresh. A level-sensitive design would fire a reset there.
- A key followed by two writes must let only the first one through. A key that stays armed would let the second write change the configuration.
- Open-window counts of 1 and 0, and a closed-window count of 0, must all give the shortest timing without an off-by-one or a stall.
- A stopped block must stay silent.
- An interrupt clear must give way to a simultaneous set.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int unsigned OFS_W = 5;
  localparam logic [OFS_W-1:0] OFS_KEY  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [OFS_W-1:0] OFS_CFG  = 5'h08;
  localparam logic [OFS_W-1:0] OFS_FW   = 5'h0C;
  localparam logic [OFS_W-1:0] OFS_SW   = 5'h10;
  localparam int unsigned BIT_EN  = 0;
  localparam int unsigned BIT_SEL = 8;
  localparam int unsigned BIT_IRQ = 16;
  typedef enum logic [1:0] {PH_OFF, PH_CLOSED, PH_OPEN} phase_t;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              w2_entry,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fw_cnt,
  output logic [CNT_W-1:0]  sw_cnt,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              evt_refresh,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_FW   = ADDR_W'(OFS_FW);
  localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(OFS_SW);

  logic              unlock_q, en_q, sel_q, irq_q;
  logic [DATA_W-1:0] cfg_q;
  logic [CNT_W-1:0]  fw_q, sw_q;
  logic [DATA_W-1:0] rd_d;
  logic              key_wr, other_wr, granted, ctrl_wr;

  assign key_wr   = wr_en && (addr == A_KEY);
  assign other_wr = wr_en && (addr != A_KEY);
  assign granted  = other_wr && unlock_q;
  assign ctrl_wr  = granted && (addr == A_CTRL);

  assign evt_start   = ctrl_wr && wr_data[BIT_EN] && !en_q;
  assign evt_stop    = ctrl_wr && !wr_data[BIT_EN];
  assign evt_refresh = ctrl_wr && wr_data[BIT_EN] && en_q && wr_data[BIT_SEL] && !sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q <= 1'b0;
      en_q     <= 1'b0;
      sel_q    <= 1'b0;
      irq_q    <= 1'b0;
      cfg_q    <= '0;
      fw_q     <= '0;
      sw_q     <= '0;
    end else begin
      if (key_wr)        unlock_q <= wr_data[0];
      else if (other_wr) unlock_q <= 1'b0;
      if (ctrl_wr) begin
        en_q  <= wr_data[BIT_EN];
        sel_q <= wr_data[BIT_SEL];
      end
      if (w2_entry)                          irq_q <= 1'b1;
      else if (ctrl_wr && wr_data[BIT_IRQ])  irq_q <= 1'b0;
      if (granted && addr == A_CFG) cfg_q <= wr_data;
      if (granted && addr == A_FW)  fw_q  <= wr_data[CNT_W-1:0];
      if (granted && addr == A_SW)  sw_q  <= wr_data[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      A_KEY:  rd_d[0] = unlock_q;
      A_CTRL: begin
        rd_d[BIT_EN]  = en_q;
        rd_d[BIT_SEL] = sel_q;
        rd_d[BIT_IRQ] = irq_q;
      end
      A_CFG:  rd_d = cfg_q;
      A_FW:   rd_d = DATA_W'(fw_q);
      A_SW:   rd_d = DATA_W'(sw_q);
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_d;
  end

  assign fw_cnt = fw_q;
  assign sw_cnt = sw_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/wwd_timer.sv
module wwd_timer
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             refresh,
  input  logic [CNT_W-1:0] fw_cnt,
  input  logic [CNT_W-1:0] sw_cnt,
  output logic             w2_entry,
  output logic             wdt_rst
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_t           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fire, reload;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    fire     = 1'b0;
    reload   = 1'b0;
    w2_entry = 1'b0;
    if (stop) begin
      ph_d = PH_OFF;
    end else if (start) begin
      reload = 1'b1;
    end else begin
      case (ph_q)
        PH_CLOSED: begin
          if (refresh) begin
            fire   = 1'b1;
            reload = 1'b1;
          end else if (cnt_q <= ONE) begin
            ph_d     = PH_OPEN;
            cnt_d    = sw_cnt;
            w2_entry = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_OPEN: begin
          if (refresh) begin
            reload = 1'b1;
          end else if (cnt_q <= ONE) begin
            fire   = 1'b1;
            reload = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: ;
      endcase
    end
    if (reload) begin
      if (fw_cnt == '0) begin
        ph_d     = PH_OPEN;
        cnt_d    = sw_cnt;
        w2_entry = 1'b1;
      end else begin
        ph_d  = PH_CLOSED;
        cnt_d = fw_cnt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_OFF;
      cnt_q   <= '0;
      wdt_rst <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      wdt_rst <= fire;
    end
  end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wdt_rst_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] fw_cnt, sw_cnt;
  logic             evt_start, evt_stop, evt_refresh, w2_entry;

  wwd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .w2_entry(w2_entry), .rd_data(rd_data), .fw_cnt(fw_cnt), .sw_cnt(sw_cnt),
    .evt_start(evt_start), .evt_stop(evt_stop), .evt_refresh(evt_refresh),
    .irq_o(irq_o)
  );

  wwd_timer #(.CNT_W(CNT_W)) u_tim (
    .clk(clk), .rst(rst), .start(evt_start), .stop(evt_stop),
    .refresh(evt_refresh), .fw_cnt(fw_cnt), .sw_cnt(sw_cnt),
    .w2_entry(w2_entry), .wdt_rst(wdt_rst_o)
  );
endmodule

// File: rtl/wwd_chk.sv
module wwd_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              unlock,
  input logic              en,
  input logic [CNT_W-1:0]  fw_cnt,
  input logic              w2_entry,
  input logic              irq,
  input logic              wdt_rst
);
  localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(wwd_pkg::OFS_KEY);
  localparam logic [ADDR_W-1:0] A_FW  = ADDR_W'(wwd_pkg::OFS_FW);

  assert_key_consumed_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != A_KEY) |=> !unlock);

  assert_locked_write_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_FW && !unlock) |=> $stable(fw_cnt));

  assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wdt_rst);

  assert_irq_on_open_R8: assert property (@(posedge clk) disable iff (rst)
    w2_entry |=> irq);
endmodule

bind win_watchdog wwd_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
  .unlock(u_regs.unlock_q), .en(u_regs.en_q), .fw_cnt(fw_cnt),
  .w2_entry(w2_entry), .irq(irq_o), .wdt_rst(wdt_rst_o)
);

// File: tb/sim_win_watchdog.sv
`timescale 1ns/1ps
module sim_win_watchdog;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wdt_rst_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  win_watchdog u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
  );

  // reference model state
  bit m_unl, m_en, m_sel, m_irq, m_rst;
  longint m_cfg, m_fw, m_sw, m_cnt;
  int m_ph; // 0 off, 1 closed, 2 open
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_unl = 0; m_en = 0; m_sel = 0; m_irq = 0; m_rst = 0;
      m_cfg = 0; m_fw = 0; m_sw = 0; m_cnt = 0; m_ph = 0; m_rd = 0;
    end else begin
      bit other, ok, cw, st, sp, rf, ent, boom, rl;
      case (addr)
        5'h00: m_rd = {31'b0, m_unl};
        5'h04: m_rd = (32'(m_irq) << 16) | (32'(m_sel) << 8) | 32'(m_en);
        5'h08: m_rd = m_cfg[31:0];
        5'h0C: m_rd = m_fw[31:0];
        5'h10: m_rd = m_sw[31:0];
        default: m_rd = 0;
      endcase
      other = wr_en && addr != 5'h00;
      ok = other && m_unl;
      cw = ok && addr == 5'h04;
      st = cw && wr_data[0] && !m_en;
      sp = cw && !wr_data[0];
      rf = cw && wr_data[0] && m_en && wr_data[8] && !m_sel;
      ent = 0; boom = 0; rl = 0;
      if (sp) m_ph = 0;
      else if (st) rl = 1;
      else if (m_ph == 1) begin
        if (rf) begin boom = 1; rl = 1; end
        else if (m_cnt <= 1) begin m_ph = 2; m_cnt = m_sw; ent = 1; end
        else m_cnt--;
      end else if (m_ph == 2) begin
        if (rf) rl = 1;
        else if (m_cnt <= 1) begin boom = 1; rl = 1; end
        else m_cnt--;
      end
      if (rl) begin
        if (m_fw == 0) begin m_ph = 2; m_cnt = m_sw; ent = 1; end
        else begin m_ph = 1; m_cnt = m_fw; end
      end
      m_rst = boom;
      if (ent) m_irq = 1;
      else if (cw && wr_data[16]) m_irq = 0;
      if (cw) begin m_en = wr_data[0]; m_sel = wr_data[8]; end
      if (ok && addr == 5'h08) m_cfg = wr_data;
      if (ok && addr == 5'h0C) m_fw = wr_data;
      if (ok && addr == 5'h10) m_sw = wr_data;
      if (wr_en && addr == 5'h00) m_unl = wr_data[0];
      else if (other) m_unl = 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 reset pulse vs model", 32'(wdt_rst_o), 32'(m_rst));
      chk("R8 irq vs model", 32'(irq_o), 32'(m_irq));
      chk("R9 read data vs model", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic uwr(input logic [4:0] a, input logic [31:0] d);
    wr(5'h00, 32'h1);
    wr(a, d);
  endtask

  task automatic rdchk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic until_rst(output int n);
    n = 0;
    while (!wdt_rst_o && n < 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    int hits;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 reset out", 32'(wdt_rst_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rdchk(5'h04, 0, "R1 ctrl");
    rdchk(5'h10, 0, "R1 open count");
    // R3: locked writes
    wr(5'h10, 32'd5);
    rdchk(5'h10, 0, "R3 locked count write");
    wr(5'h04, 32'h1);
    rdchk(5'h04, 0, "R3 locked enable");
    // R2: key covers one write
    wr(5'h00, 32'h1);
    rdchk(5'h00, 1, "R2 key armed");
    wr(5'h08, 32'd7);
    wr(5'h08, 32'd9);
    rdchk(5'h08, 7, "R2 second write blocked");
    rdchk(5'h00, 0, "R2 key consumed");
    // counts
    uwr(5'h0C, 32'd3);
    uwr(5'h10, 32'd5);
    rdchk(5'h0C, 3, "R9 closed count");
    // R5: expiry after F+S
    uwr(5'h04, 32'h1);
    until_rst(n);
    chk("R5 expiry cycles", n, 8);
    chk("R8 irq set in open window", 32'(irq_o), 1);
    @(negedge clk);
    chk("R5 single pulse", 32'(wdt_rst_o), 0);
    // R6: refresh on last closed cycle is a violation
    uwr(5'h04, 32'h101);
    chk("R6 closed refresh violation", 32'(wdt_rst_o), 1);
    // R4 stop, R8 clear
    uwr(5'h04, 32'h0);
    uwr(5'h04, 32'h10000);
    chk("R8 irq cleared", 32'(irq_o), 0);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (wdt_rst_o) hits++;
    end
    chk("R4 silent while stopped", hits, 0);
    // R6: refresh in open window
    uwr(5'h0C, 32'd2);
    uwr(5'h10, 32'd6);
    uwr(5'h04, 32'h1);
    while (!irq_o) @(negedge clk);
    uwr(5'h04, 32'h101);
    chk("R6 open refresh no reset", 32'(wdt_rst_o), 0);
    until_rst(n);
    chk("R6 period restarted", n, 8);
    // R6: select already 1 is not a refresh
    uwr(5'h04, 32'h101);
    chk("R6 no refresh without edge", 32'(wdt_rst_o), 0);
    // R7 and shortest open window
    uwr(5'h04, 32'h0);
    uwr(5'h0C, 32'd0);
    uwr(5'h10, 32'd1);
    uwr(5'h04, 32'h10000);
    chk("R8 irq cleared again", 32'(irq_o), 0);
    uwr(5'h04, 32'h1);
    chk("R7 open at start", 32'(irq_o), 1);
    @(negedge clk);
    chk("R5 count of one", 32'(wdt_rst_o), 1);
    // zero open count behaves as one
    uwr(5'h04, 32'h0);
    uwr(5'h10, 32'd0);
    uwr(5'h04, 32'h1);
    @(negedge clk);
    chk("R5 count of zero", 32'(wdt_rst_o), 1);
    rdchk(5'h14, 0, "R9 unmapped offset");
    uwr(5'h04, 32'h0);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule